// File: doc/BRIEF.md
# Random Word Holding Buffer with Ready Flag

This block sits between a whitening stage that produces random bytes on a dedicated generator clock and a host that reads 32-bit random values on its own bus clock. On the generator side it packs incoming bytes into two 16-bit words, four bytes in all, and ignores any further bytes until the host has taken the value. A counter on the generator side keeps the value from being announced until a minimum number of generator cycles has passed since the buffer was last emptied. This holds even when the bytes arrive faster.

On the bus side the block raises a ready flag once the full value is announced. A single read returns the whole 32-bit value, empties the buffer and drops the flag. An optional interrupt is raised together with the flag and falls by itself when the flag falls. The full and emptied events cross between the two clocks as toggles through multi-flop synchronizers. The 32-bit value is held steady on the generator side until the emptied event comes back, so the bus side can sample it at any time while the flag is high.

Top module: `rng_hold_buf`

## Requirements
- R1: After reset, ready_o and irq_o are 0, and rd_data_o is 0.
- R2: Bytes are packed in arrival order. The first byte goes to rd_data_o[7:0], the second to [15:8], the third to [23:16] and the fourth to [31:24], so the first 16-bit word occupies bits 15:0.
- R3: At most four bytes are stored per value. Bytes that arrive after the fourth, and before the host has read the value, are dropped.
- R4: ready_o does not rise until at least 42 generator-clock cycles have elapsed since reset or since the buffer was last emptied, even if all four bytes arrived earlier.
- R5: Once four bytes are stored and the 42-cycle hold has passed, ready_o rises after the status crosses into the bus domain.
- R6: A read strobe (rd_i high for one bus cycle) while ready_o is 1 places the stored value on rd_data_o in the next bus cycle, and ready_o is 0 in that same cycle.
- R7: A read strobe while ready_o is 0 puts 0 on rd_data_o in the next bus cycle and does not change the stored bytes or the fill progress.
- R8: When irq_en_i is 1 at the moment ready_o rises, irq_o rises with it. When irq_en_i is 0 at that moment, irq_o stays 0.
- R9: irq_o is never 1 while ready_o is 0. It falls together with ready_o after a read.
- R10: After a read, ready_o stays 0 until four new bytes have arrived and a fresh 42-cycle hold has passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rng_clk_i | input | 1 | Generator clock |
| rng_rst_ni | input | 1 | Active-low asynchronous reset, generator domain |
| byte_valid_i | input | 1 | A whitened byte is present this generator cycle |
| byte_i | input | 8 | Whitened byte |
| bus_clk_i | input | 1 | Host bus clock |
| bus_rst_ni | input | 1 | Active-low asynchronous reset, bus domain |
| irq_en_i | input | 1 | Interrupt enable |
| rd_i | input | 1 | Read strobe for the 32-bit value |
| rd_data_o | output | 32 | Value returned by the last read strobe |
| ready_o | output | 1 | A full 32-bit value is waiting |
| irq_o | output | 1 | Interrupt, raised with ready_o when enabled |

## Verification
The hardest situation to reach is the hold timer deciding the outcome: all four bytes present and ready_o still low. The bench delivers the bytes in the first few generator cycles after an empty buffer. It then probes ready_o and issues a read at around 20 generator cycles, while it counts generator edges on its own to check that the rise comes no earlier than 42. A second hard case is a stream that runs past four bytes. The bench keeps feeding bytes after the fourth and checks that only the first four appear in the read value. It also leaves the buffer idle after a read to confirm that no refill happens without new bytes.

// File: rtl/rng_hold_pkg.sv
package rng_hold_pkg;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned WORD_W  = 16;
    localparam int unsigned N_WORDS = 2;
    localparam int unsigned VALUE_W = WORD_W * N_WORDS;
    localparam int unsigned N_BYTES = VALUE_W / BYTE_W;
endpackage

// File: rtl/rng_hold_sync.sv
module rng_hold_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = d_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rng_hold_fill.sv
module rng_hold_fill
    import rng_hold_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 42
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               byte_valid_i,
    input  logic [BYTE_W-1:0]  byte_i,
    input  logic               empty_tgl_i,
    output logic               full_tgl_o,
    output logic [VALUE_W-1:0] value_o
);
    localparam int unsigned CNT_W = $clog2(N_BYTES + 1);
    localparam int unsigned CYC_W = $clog2(HOLD_CYCLES + 1);

    typedef struct packed {
        logic [VALUE_W-1:0] data;
        logic [CNT_W-1:0]   cnt;
        logic [CYC_W-1:0]   cyc;
        logic               full_tgl;
        logic               waiting;
        logic               ack_seen;
    } fill_state_t;

    fill_state_t s_d, s_q;
    logic        ack_edge;

    always_comb begin
        s_d        = s_q;
        ack_edge   = (empty_tgl_i != s_q.ack_seen);
        s_d.ack_seen = empty_tgl_i;
        if (ack_edge) begin
            s_d.cnt     = '0;
            s_d.cyc     = '0;
            s_d.waiting = 1'b0;
        end else begin
            if (s_q.cyc < CYC_W'(HOLD_CYCLES)) s_d.cyc = s_q.cyc + 1'b1;
            if (byte_valid_i && (s_q.cnt < CNT_W'(N_BYTES))) begin
                for (int i = 0; i < int'(N_BYTES); i++) begin
                    if (s_q.cnt == CNT_W'(i)) s_d.data[i*BYTE_W +: BYTE_W] = byte_i;
                end
                s_d.cnt = s_q.cnt + 1'b1;
            end
            if (!s_q.waiting && (s_q.cnt == CNT_W'(N_BYTES)) &&
                (s_q.cyc == CYC_W'(HOLD_CYCLES))) begin
                s_d.full_tgl = ~s_q.full_tgl;
                s_d.waiting  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign full_tgl_o = s_q.full_tgl;
    assign value_o    = s_q.data;

    // R3
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.cnt <= CNT_W'(N_BYTES));

    // R4
    hold_before_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.full_tgl != $past(s_q.full_tgl)) |->
            ($past(s_q.cyc) == CYC_W'(HOLD_CYCLES) && $past(s_q.cnt) == CNT_W'(N_BYTES)));

    // R3
    data_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(s_q.waiting) && s_q.waiting) |-> $stable(s_q.data));
endmodule

// File: rtl/rng_hold_host.sv
module rng_hold_host
    import rng_hold_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               full_tgl_i,
    input  logic [VALUE_W-1:0] value_i,
    input  logic               irq_en_i,
    input  logic               rd_i,
    output logic               empty_tgl_o,
    output logic [VALUE_W-1:0] rd_data_o,
    output logic               ready_o,
    output logic               irq_o
);
    typedef struct packed {
        logic [VALUE_W-1:0] rd_data;
        logic               ready;
        logic               irq;
        logic               full_seen;
        logic               empty_tgl;
    } host_state_t;

    host_state_t s_d, s_q;
    logic        full_edge;

    always_comb begin
        s_d           = s_q;
        full_edge     = (full_tgl_i != s_q.full_seen);
        s_d.full_seen = full_tgl_i;
        if (rd_i) begin
            if (s_q.ready) begin
                s_d.rd_data   = value_i;
                s_d.ready     = 1'b0;
                s_d.irq       = 1'b0;
                s_d.empty_tgl = ~s_q.empty_tgl;
            end else begin
                s_d.rd_data = '0;
            end
        end
        if (full_edge) begin
            s_d.ready = 1'b1;
            s_d.irq   = irq_en_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign empty_tgl_o = s_q.empty_tgl;
    assign rd_data_o   = s_q.rd_data;
    assign ready_o     = s_q.ready;
    assign irq_o       = s_q.irq;

    // R6
    read_clears_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && ready_o) |=> !ready_o);

    // R7
    idle_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !ready_o) |=> (rd_data_o == '0));

    // R8
    irq_follows_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ready_o) |-> (irq_o == $past(irq_en_i)));

    // R9
    irq_needs_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ready_o |-> !irq_o);
endmodule

// File: rtl/rng_hold_buf.sv
module rng_hold_buf
    import rng_hold_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 42,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               rng_clk_i,
    input  logic               rng_rst_ni,
    input  logic               byte_valid_i,
    input  logic [BYTE_W-1:0]  byte_i,
    input  logic               bus_clk_i,
    input  logic               bus_rst_ni,
    input  logic               irq_en_i,
    input  logic               rd_i,
    output logic [VALUE_W-1:0] rd_data_o,
    output logic               ready_o,
    output logic               irq_o
);
    logic               full_tgl_rng, full_tgl_bus;
    logic               empty_tgl_bus, empty_tgl_rng;
    logic [VALUE_W-1:0] value_rng;

    rng_hold_fill #(.HOLD_CYCLES(HOLD_CYCLES)) fill_i (
        .clk_i        (rng_clk_i),
        .rst_ni       (rng_rst_ni),
        .byte_valid_i (byte_valid_i),
        .byte_i       (byte_i),
        .empty_tgl_i  (empty_tgl_rng),
        .full_tgl_o   (full_tgl_rng),
        .value_o      (value_rng)
    );

    rng_hold_sync #(.STAGES(SYNC_STAGES)) full_sync_i (
        .clk_i  (bus_clk_i),
        .rst_ni (bus_rst_ni),
        .d_i    (full_tgl_rng),
        .q_o    (full_tgl_bus)
    );

    rng_hold_sync #(.STAGES(SYNC_STAGES)) empty_sync_i (
        .clk_i  (rng_clk_i),
        .rst_ni (rng_rst_ni),
        .d_i    (empty_tgl_bus),
        .q_o    (empty_tgl_rng)
    );

    rng_hold_host host_i (
        .clk_i       (bus_clk_i),
        .rst_ni      (bus_rst_ni),
        .full_tgl_i  (full_tgl_bus),
        .value_i     (value_rng),
        .irq_en_i    (irq_en_i),
        .rd_i        (rd_i),
        .empty_tgl_o (empty_tgl_bus),
        .rd_data_o   (rd_data_o),
        .ready_o     (ready_o),
        .irq_o       (irq_o)
    );
endmodule

// File: tb/rng_hold_buf_tb.sv
module rng_hold_buf_tb_top;
    logic        rng_clk = 1'b0;
    logic        bus_clk = 1'b0;
    logic        rng_rst_n = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_v = 8'h00;
    logic        irq_en = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] rd_data;
    logic        ready, irq;

    int errors = 0;
    int checks = 0;
    int rng_cnt = 0;
    int bus_cyc = 0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 bus_clk = ~bus_clk;
    always #3.5 rng_clk = ~rng_clk;

    rng_hold_buf dut_i (
        .rng_clk_i    (rng_clk),
        .rng_rst_ni   (rng_rst_n),
        .byte_valid_i (byte_valid),
        .byte_i       (byte_v),
        .bus_clk_i    (bus_clk),
        .bus_rst_ni   (bus_rst_n),
        .irq_en_i     (irq_en),
        .rd_i         (rd),
        .rd_data_o    (rd_data),
        .ready_o      (ready),
        .irq_o        (irq)
    );

    always @(posedge rng_clk) rng_cnt <= rng_cnt + 1;
    always @(posedge bus_clk) rd_seen <= rd;

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard when a read result appears
    always @(negedge bus_clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) check(1'b0, "scoreboard-empty", rd_data, 32'h0);
            else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data == e, t, rd_data, e);
            end
        end
    end

    // watchdog
    always @(posedge bus_clk) begin
        bus_cyc <= bus_cyc + 1;
        if (bus_cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", bus_cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic send_byte(input logic [7:0] b);
        @(negedge rng_clk);
        byte_valid = 1'b1;
        byte_v     = b;
        @(negedge rng_clk);
        byte_valid = 1'b0;
    endtask

    task automatic do_read(input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge bus_clk);
        rd = 1'b1;
        @(negedge bus_clk);
        rd = 1'b0;
    endtask

    task automatic wait_ready(output int waited);
        waited = 0;
        while (!ready && waited < 3000) begin
            @(negedge bus_clk);
            waited++;
        end
    endtask

    task automatic idle_rng(input int n);
        repeat (n) @(negedge rng_clk);
    endtask

    initial begin
        int w;
        int start;
        repeat (4) @(negedge bus_clk);
        rng_rst_n = 1'b1;
        bus_rst_n = 1'b1;
        start = rng_cnt;
        @(negedge bus_clk);
        // R1
        check(ready == 1'b0, "R1 ready", {31'b0, ready}, 32'h0);
        check(irq == 1'b0, "R1 irq", {31'b0, irq}, 32'h0);
        check(rd_data == 32'h0, "R1 rd_data", rd_data, 32'h0);

        irq_en = 1'b1;
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
        idle_rng(10);
        // R4: bytes present, hold not yet elapsed
        check(ready == 1'b0, "R4 early", {31'b0, ready}, 32'h0);
        do_read(32'h0, "R7 idle read");
        @(negedge bus_clk);
        check(ready == 1'b0, "R7 state kept", {31'b0, ready}, 32'h0);
        wait_ready(w);
        // R5
        check(ready == 1'b1, "R5 ready rises", {31'b0, ready}, 32'h1);
        check((rng_cnt - start) >= 42, "R4 hold cycles", rng_cnt - start, 42);
        // R8
        check(irq == 1'b1, "R8 irq enabled", {31'b0, irq}, 32'h1);
        do_read(32'h44332211, "R2 byte order / R7 buffer intact");
        // R6
        check(ready == 1'b0, "R6 ready falls", {31'b0, ready}, 32'h0);
        // R9
        check(irq == 1'b0, "R9 irq falls", {31'b0, irq}, 32'h0);
        do_read(32'h0, "R7 read after empty");

        irq_en = 1'b0;
        start = rng_cnt;
        send_byte(8'ha1); send_byte(8'ha2); send_byte(8'ha3); send_byte(8'ha4);
        send_byte(8'ha5); send_byte(8'ha6);
        wait_ready(w);
        check(ready == 1'b1, "R5 second fill", {31'b0, ready}, 32'h1);
        check((rng_cnt - start) >= 42, "R10 fresh hold", rng_cnt - start, 42);
        check(irq == 1'b0, "R8 irq disabled", {31'b0, irq}, 32'h0);
        send_byte(8'hb7);
        do_read(32'ha4a3a2a1, "R3 extra bytes dropped");

        idle_rng(90);
        // R10: no bytes, no refill
        check(ready == 1'b0, "R10 no refill", {31'b0, ready}, 32'h0);

        irq_en = 1'b1;
        send_byte(8'h5a); idle_rng(15);
        send_byte(8'hc3); idle_rng(15);
        send_byte(8'h0f); idle_rng(15);
        check(ready == 1'b0, "R10 three bytes", {31'b0, ready}, 32'h0);
        send_byte(8'hf0);
        wait_ready(w);
        check(ready == 1'b1, "R5 slow fill", {31'b0, ready}, 32'h1);
        check(irq == 1'b1, "R8 irq re-enabled", {31'b0, irq}, 32'h1);
        do_read(32'hf00fc35a, "R2 slow fill value");
        do_read(32'h0, "R7 back-to-back read");
        check(irq == 1'b0, "R9 irq after read", {31'b0, irq}, 32'h0);

        repeat (4) @(negedge bus_clk);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule